// File: doc/BRIEF.md
# Interrupt Pending Controller with Channel-Loop Aggregation

This block gathers single-cycle event pulses from a set of interrupt sources and from 64 per-channel loop events. It latches each one as a sticky pending bit and reduces them to one registered interrupt line. The global pending word holds the source bits and also reports a channel-loop summary bit and the number of the highest enabled pending channel. This lets a handler find and acknowledge channels one at a time without reading both channel words.

Software sees six 32-bit words on a simple synchronous register port. Reads are combinational from the address. A write takes effect at the clock edge where `reg_wr` is high. Pending bits are write-1-to-clear. Writing the global word with the summary bit set also acknowledges one channel, chosen by the index written beside it.

Top module: `irq_pend_ctl`

## Requirements
- R1: A pulse on `src_evt[k]` sets global pending bit 7+k at the next clock edge (source 0 at bit 7, source 1 at bit 8, source 2 at bit 9). The bit stays set until it is cleared.
- R2: A write to address 0 clears each source pending bit (bits 31:7) written as 1. Bits written as 0 keep their value.
- R3: A pulse on `ch_evt[c]` sets channel-loop pending bit c. Channels 0-31 read at address 2 (bit c) and channels 32-63 read at address 3 (bit c-32). Pending bits read raw, without masking.
- R4: Bit 6 of address 0 reads 1 exactly when some channel is both pending and enabled. Channel enables are the words at address 4 (channels 0-31) and address 5 (channels 32-63).
- R5: While bit 6 is 1, bits 5:0 of address 0 hold the highest enabled pending channel number. While bit 6 is 0, they read 0.
- R6: A write to address 0 with bit 6 set clears only the channel pending bit named by bits 5:0 of the written value. With bit 6 clear, no channel bit changes.
- R7: A write to address 2 or 3 clears each channel pending bit of that word written as 1.
- R8: An event that arrives in the same cycle as a write that clears its bit leaves the bit set.
- R9: `irq_o` is the OR of every source pending bit ANDed with its enable, ORed with the bit-6 summary, registered once. Enable bit k at address 1 gates source k, so the timer source at bit 9 uses enable bit 2.
- R10: Bit 31 of address 1 forces `irq_o` high continuously, whatever the pending state.
- R11: Reset clears every pending bit, every enable and force, and drives `irq_o` low.
- R12: Address 1 reads back bits 24:0 and 31 as written and reads 0 in bits 30:25. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| src_evt | input | 25 | Source event pulses; source k maps to pending bit 7+k |
| ch_evt | input | 64 | Channel-loop event pulses, one per channel |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions take the event inputs to be synchronous to `clk` and treat any high cycle as one event. The stimulus holds each pulse for exactly one cycle and changes no input near the rising edge. The rule that a pending bit rises only after an event assumes no other path sets it, so the bench never forces internal state. It drives all traffic on the falling edge and samples reads one delta after the address settles, which keeps every write and event aligned to a single rising edge.

// File: rtl/irq_pend_ctl.sv
module irq_pend_ctl #(
  parameter int NUM_CH = 64,
  parameter int DW     = 32,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [DW-$clog2(NUM_CH)-2:0] src_evt,
  input  logic [NUM_CH-1:0] ch_evt,
  output logic              irq_o
);
  localparam int IDX_W     = $clog2(NUM_CH);
  localparam int SUM_BIT   = IDX_W;
  localparam int SRC_BASE  = IDX_W + 1;
  localparam int NSRC      = DW - SRC_BASE;
  localparam int CH_WORDS  = NUM_CH / DW;
  localparam int AD_GLOB   = 0;
  localparam int AD_EN     = 1;
  localparam int AD_PEND0  = 2;
  localparam int AD_CHEN0  = AD_PEND0 + CH_WORDS;

  logic [NSRC-1:0]   src_pend, src_en;
  logic              force_q;
  logic [NUM_CH-1:0] ch_pend, ch_en, ch_act, ch_clr, ch_en_nxt;
  logic [IDX_W-1:0]  top_idx;
  logic              summary, irq_q;

  wire wr_glob = reg_wr && (reg_addr == AW'(AD_GLOB));
  wire wr_en   = reg_wr && (reg_addr == AW'(AD_EN));
  wire [NSRC-1:0] src_clr = wr_glob ? reg_wdata[DW-1:SRC_BASE] : '0;

  assign ch_act  = ch_pend & ch_en;
  assign summary = |ch_act;

  always_comb begin
    top_idx = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (ch_act[i]) top_idx = IDX_W'(i);
  end

  always_comb begin
    ch_clr    = '0;
    ch_en_nxt = ch_en;
    for (int w = 0; w < CH_WORDS; w++) begin
      if (reg_wr && reg_addr == AW'(AD_PEND0 + w))
        ch_clr[w*DW +: DW] = reg_wdata;
      if (reg_wr && reg_addr == AW'(AD_CHEN0 + w))
        ch_en_nxt[w*DW +: DW] = reg_wdata;
    end
    if (wr_glob && reg_wdata[SUM_BIT])
      ch_clr[reg_wdata[IDX_W-1:0]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_pend <= '0;
      src_en   <= '0;
      force_q  <= 1'b0;
      ch_pend  <= '0;
      ch_en    <= '0;
      irq_q    <= 1'b0;
    end else begin
      src_pend <= (src_pend & ~src_clr) | src_evt;
      ch_pend  <= (ch_pend & ~ch_clr) | ch_evt;
      ch_en    <= ch_en_nxt;
      if (wr_en) begin
        src_en  <= reg_wdata[NSRC-1:0];
        force_q <= reg_wdata[DW-1];
      end
      irq_q <= force_q | (|(src_pend & src_en)) | summary;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(AD_GLOB))
      reg_rdata = {src_pend, summary, summary ? top_idx : {IDX_W{1'b0}}};
    else if (reg_addr == AW'(AD_EN))
      reg_rdata = {force_q, {(DW-1-NSRC){1'b0}}, src_en};
    for (int w = 0; w < CH_WORDS; w++) begin
      if (reg_addr == AW'(AD_PEND0 + w)) reg_rdata = ch_pend[w*DW +: DW];
      if (reg_addr == AW'(AD_CHEN0 + w)) reg_rdata = ch_en[w*DW +: DW];
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk #(
  parameter int NUM_CH = 64,
  parameter int NSRC   = 25,
  parameter int IDX_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              force_q,
  input logic [NSRC-1:0]   src_evt,
  input logic [NSRC-1:0]   src_pend,
  input logic [NSRC-1:0]   src_en,
  input logic [NUM_CH-1:0] ch_evt,
  input logic [NUM_CH-1:0] ch_pend,
  input logic [NUM_CH-1:0] ch_en,
  input logic              summary,
  input logic [IDX_W-1:0]  top_idx,
  input logic              irq_o
);
  AST_SRC_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (|src_evt) |=> ((src_pend & $past(src_evt)) == $past(src_evt))); // R8
  AST_CH_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (|ch_evt) |=> ((ch_pend & $past(ch_evt)) == $past(ch_evt))); // R3
  AST_CH_NO_SPUR: assert property (@(posedge clk) disable iff (!rst_n) ((ch_pend & ~$past(ch_pend) & ~$past(ch_evt)) == '0)); // R3
  AST_IDX_VALID: assert property (@(posedge clk) disable iff (!rst_n) summary |-> (ch_pend[top_idx] && ch_en[top_idx])); // R5
  AST_FORCE_IRQ: assert property (@(posedge clk) disable iff (!rst_n) force_q |=> irq_o); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!force_q && ((src_pend & src_en) == '0) && !summary) |=> !irq_o); // R9
endmodule

bind irq_pend_ctl irq_pend_chk #(.NUM_CH(NUM_CH), .NSRC(NSRC), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .force_q(force_q), .src_evt(src_evt), .src_pend(src_pend),
  .src_en(src_en), .ch_evt(ch_evt), .ch_pend(ch_pend), .ch_en(ch_en), .summary(summary),
  .top_idx(top_idx), .irq_o(irq_o)
);

// File: tb/tb_irq_pend_ctl.sv
module tb_irq_pend_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [24:0] src_evt = '0;
  logic [63:0] ch_evt = '0;
  logic        irq_o;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_pend_ctl dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_evt(src_evt), .ch_evt(ch_evt), .irq_o(irq_o));

  localparam logic [2:0] W = 3'd0, R = 3'd1, S = 3'd2, C = 3'd3, I = 3'd4;
  localparam int NV = 46;
  // {op, addr, data, expected, requirement number}
  localparam logic [77:0] VEC [NV] = '{
    {R, 3'd0, 32'h0, 32'h0, 8'd11},          // R11
    {R, 3'd1, 32'h0, 32'h0, 8'd11},          // R11
    {I, 3'd0, 32'h0, 32'h0, 8'd11},          // R11
    {S, 3'd0, 32'h4, 32'h0, 8'd1},
    {R, 3'd0, 32'h0, 32'h200, 8'd1},         // R1
    {S, 3'd0, 32'h3, 32'h0, 8'd1},
    {R, 3'd0, 32'h0, 32'h380, 8'd1},         // R1
    {W, 3'd0, 32'h100, 32'h0, 8'd2},
    {R, 3'd0, 32'h0, 32'h280, 8'd2},         // R2
    {C, 3'd0, 32'd5, 32'h0, 8'd3},
    {R, 3'd2, 32'h0, 32'h20, 8'd3},          // R3
    {R, 3'd0, 32'h0, 32'h280, 8'd4},         // R4 not enabled
    {W, 3'd4, 32'h20, 32'h0, 8'd4},
    {R, 3'd0, 32'h0, 32'h2C5, 8'd4},         // R4
    {C, 3'd0, 32'd40, 32'h0, 8'd3},
    {R, 3'd3, 32'h0, 32'h100, 8'd3},         // R3
    {W, 3'd5, 32'h100, 32'h0, 8'd5},
    {R, 3'd0, 32'h0, 32'h2E8, 8'd5},         // R5
    {W, 3'd0, 32'h68, 32'h0, 8'd6},
    {R, 3'd3, 32'h0, 32'h0, 8'd6},           // R6
    {R, 3'd2, 32'h0, 32'h20, 8'd6},          // R6
    {R, 3'd0, 32'h0, 32'h2C5, 8'd6},         // R6
    {W, 3'd0, 32'h05, 32'h0, 8'd6},
    {R, 3'd2, 32'h0, 32'h20, 8'd6},          // R6 bit 6 clear
    {W, 3'd2, 32'h20, 32'h0, 8'd7},
    {R, 3'd2, 32'h0, 32'h0, 8'd7},           // R7
    {R, 3'd0, 32'h0, 32'h280, 8'd7},         // R7
    {W, 3'd1, 32'hFFFFFFFF, 32'h0, 8'd12},
    {R, 3'd1, 32'h0, 32'h81FFFFFF, 8'd12},   // R12
    {W, 3'd1, 32'h0, 32'h0, 8'd9},
    {I, 3'd0, 32'h0, 32'h0, 8'd9},           // R9
    {W, 3'd1, 32'h4, 32'h0, 8'd9},
    {I, 3'd0, 32'h0, 32'h1, 8'd9},           // R9
    {W, 3'd0, 32'h200, 32'h0, 8'd9},
    {I, 3'd0, 32'h0, 32'h0, 8'd9},           // R9
    {W, 3'd1, 32'h80000000, 32'h0, 8'd10},
    {I, 3'd0, 32'h0, 32'h1, 8'd10},          // R10
    {R, 3'd0, 32'h0, 32'h80, 8'd2},          // R2
    {W, 3'd1, 32'h0, 32'h0, 8'd10},
    {I, 3'd0, 32'h0, 32'h0, 8'd10},          // R10
    {C, 3'd0, 32'd5, 32'h0, 8'd9},
    {W, 3'd4, 32'h20, 32'h0, 8'd9},
    {I, 3'd0, 32'h0, 32'h1, 8'd9},           // R9
    {W, 3'd2, 32'h20, 32'h0, 8'd9},
    {I, 3'd0, 32'h0, 32'h0, 8'd9},           // R9
    {W, 3'd4, 32'h0, 32'h0, 8'd9}
  };

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input int req, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk); reg_addr = a; #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic irq_chk(input int req, input logic exp);
    @(negedge clk); #1;
    check(req, {31'b0, irq_o}, {31'b0, exp});
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [2:0] op; logic [2:0] a; logic [31:0] d, e; int rq;
      {op, a, d, e} = VEC[i][77:8];
      rq = int'(VEC[i][7:0]);
      case (op)
        W: wr(a, d);
        R: rd(rq, a, e);
        S: begin @(negedge clk); src_evt = d[24:0]; @(negedge clk); src_evt = '0; end
        C: begin @(negedge clk); ch_evt = 64'd1 << d[5:0]; @(negedge clk); ch_evt = '0; end
        default: irq_chk(rq, e[0]);
      endcase
    end

    // R8: source event and its clear in the same cycle
    @(negedge clk); reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h80; src_evt = 25'h1;
    @(negedge clk); reg_wr = 1'b0; src_evt = '0;
    rd(8, 3'd0, 32'h80);
    // R8: channel event and its word clear in the same cycle
    @(negedge clk); ch_evt = 64'd1 << 5;
    @(negedge clk); ch_evt = 64'd1 << 5; reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h20;
    @(negedge clk); reg_wr = 1'b0; ch_evt = '0;
    rd(8, 3'd2, 32'h20);

    // R5: highest of channels 0 and 63, then next after acknowledging 63
    wr(3'd4, 32'h1);
    wr(3'd5, 32'h80000000);
    @(negedge clk); ch_evt = (64'd1 << 63) | 64'd1;
    @(negedge clk); ch_evt = '0;
    rd(5, 3'd0, 32'hFF);
    wr(3'd0, 32'h7F);
    rd(5, 3'd0, 32'hC0);
    rd(6, 3'd3, 32'h0);

    // R11: reset in mid-run with force set
    wr(3'd1, 32'h80000000);
    irq_chk(11, 1'b1);
    @(negedge clk); rst_n = 1'b0;
    #1 check(11, {31'b0, irq_o}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    rd(11, 3'd0, 32'h0);
    rd(11, 3'd1, 32'h0);
    rd(11, 3'd2, 32'h0);
    rd(11, 3'd4, 32'h0);
    rd(12, 3'd7, 32'h0);
    irq_chk(11, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule